// File: doc/BRIEF.md
# Power-Up Mode Selection Sequencer

This block controls how a multichannel audio converter leaves reset. Once reset is released it keeps the converter in a low-power state and counts frame-clock strobes. The length of that wait depends on the sample-rate speed class. The wait ends in one of two ways. If a control-port enable write arrives first, the block switches to software mode, and the configuration then comes from register values. If the wait runs out first, the block switches to hardware mode, and the configuration comes from five strap pins. The block samples those pins once, on the cycle it enters hardware mode.

An enable write is still accepted after hardware operation has begun. It moves the block to software mode at once. In software mode a power-down register bit keeps the converter in low power until software clears it, so the other settings can be loaded first. Software mode lasts until the next reset.

An asynchronous active-low reset drives the block. Its release is synchronised internally over two clock edges. Every output comes straight from state registers or from simple selection logic, so a result appears one clock edge after the stimulus that causes it.

Top module: `pwrup_mode_seq`

## Requirements
- R1: While reset is asserted, and after its release until the wait ends, `active_mode` is 00, `low_power` is 1 and `eff_cfg` is all zeros.
- R2: Only clock cycles with `lrck_tick` high advance the wait. With `speed_sel` 00 the wait ends on the 512th strobe, with 01 on the 1024th strobe, and with 10 on the 2048th strobe. The internal count saturates and never wraps.
- R3: A `speed_sel` value of 11 gives the same 2048-strobe wait as 10.
- R4: If `cp_en_wr` is high during the wait, the block is in software mode after the next clock edge. This also holds when the write coincides with the final strobe: the write wins.
- R5: When the wait ends with no write, the block is in hardware mode after that edge. `low_power` is 0 and `eff_cfg` equals `mode_pins` as they were at that edge.
- R6: In hardware mode, later changes on `mode_pins` leave `eff_cfg` unchanged.
- R7: A `cp_en_wr` pulse in hardware mode moves the block to software mode after the next edge. `eff_cfg` then follows `reg_cfg`.
- R8: In software mode, `low_power` equals `reg_pdn`. A value of 1 keeps the converter powered down, and operation starts once it is 0.
- R9: Software mode is kept until reset. Further strobes and enable writes have no effect on it.
- R10: `active_mode` is encoded as 00 for the low-power wait, 01 for hardware mode and 10 for software mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck_tick | input | 1 | One-cycle strobe per frame-clock period |
| speed_sel | input | 2 | Speed class: 00 single, 01 double, 10 or 11 quad |
| cp_en_wr | input | 1 | Control-port enable write strobe |
| mode_pins | input | 5 | Strap pins used as the hardware-mode configuration |
| reg_cfg | input | 5 | Configuration supplied by registers for software mode |
| reg_pdn | input | 1 | Power-down register bit, 1 keeps the converter powered down |
| low_power | output | 1 | Converter held in the low-power state |
| active_mode | output | 2 | Current mode (see R10) |
| eff_cfg | output | 5 | Configuration in effect |

## Verification
A strobe or a write driven before a clock edge shows its effect on `active_mode`, `low_power` and `eff_cfg` right after that same edge. The bench therefore drives every input at a falling edge and reads the outputs at the next falling edge. Changes on `reg_cfg` and `reg_pdn` in software mode reach the outputs combinationally, so they are checked at the same falling edge at which they are driven, after a short settle delay. Reset release takes two edges to pass through the synchroniser. The bench waits three edges with no strobe before it counts any. The bench checks that the mode holds after strobe N−1 and changes after strobe N, for every speed code, with strobes on every cycle and with spaced strobes.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [1:0] {
    MD_WAIT = 2'b00,
    MD_HW   = 2'b01,
    MD_SW   = 2'b10
  } pmode_e;

  localparam logic [1:0] SPD_SINGLE = 2'b00;
  localparam logic [1:0] SPD_DOUBLE = 2'b01;

endpackage

// File: rtl/pwrup_rst_sync.sv
module pwrup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];

endmodule

// File: rtl/pwrup_frame_cnt.sv
module pwrup_frame_cnt #(
  parameter int BASE_WAIT = 512,
  parameter int CNT_W     = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic [1:0] speed,
  output logic       expire
);
  import pwrup_pkg::*;

  localparam logic [CNT_W-1:0] LIM_1X = CNT_W'(BASE_WAIT - 1);
  localparam logic [CNT_W-1:0] LIM_2X = CNT_W'(2 * BASE_WAIT - 1);
  localparam logic [CNT_W-1:0] LIM_4X = CNT_W'(4 * BASE_WAIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic             at_lim;
  logic             cnt_en;

  always_comb begin
    case (speed)
      SPD_SINGLE: limit = LIM_1X;
      SPD_DOUBLE: limit = LIM_2X;
      default:    limit = LIM_4X;
    endcase
  end

  assign at_lim = (cnt_q >= limit);
  assign cnt_en = run && tick && !at_lim;
  assign expire = run && tick && at_lim;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_4X) else $error("count beyond quad limit"); // R2

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q != '0)) else $error("count wrapped"); // R2

endmodule

// File: rtl/pwrup_mode_fsm.sv
module pwrup_mode_fsm (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic             cp_en_wr,
  output pwrup_pkg::pmode_e mode_q,
  output logic             enter_hw
);
  import pwrup_pkg::*;

  pmode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MD_WAIT: begin
        if (cp_en_wr)    mode_d = MD_SW;
        else if (expire) mode_d = MD_HW;
      end
      MD_HW:   if (cp_en_wr) mode_d = MD_SW;
      MD_SW:   mode_d = MD_SW;
      default: mode_d = MD_WAIT;
    endcase
  end

  assign enter_hw = (mode_q == MD_WAIT) && (mode_d == MD_HW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MD_WAIT;
    else        mode_q <= mode_d;
  end

  AST_SW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_SW) |=> (mode_q == MD_SW)) else $error("left software mode"); // R9

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_en_wr && mode_q != MD_SW) |=> (mode_q == MD_SW)) else $error("write ignored"); // R4

  AST_HW_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MD_HW) |=> ((mode_q != MD_HW) || $past(mode_q == MD_WAIT))) else $error("bad hw entry"); // R5

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'b11) else $error("illegal mode code"); // R10

endmodule

// File: rtl/pwrup_cfg_sel.sv
module pwrup_cfg_sel #(
  parameter int CFG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pwrup_pkg::pmode_e mode,
  input  logic             enter_hw,
  input  logic [CFG_W-1:0] pins,
  input  logic [CFG_W-1:0] reg_cfg,
  input  logic             reg_pdn,
  output logic [CFG_W-1:0] eff_cfg,
  output logic             low_power
);
  import pwrup_pkg::*;

  logic [CFG_W-1:0] pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pin_q <= '0;
    else if (enter_hw) pin_q <= pins;
  end

  always_comb begin
    case (mode)
      MD_HW: begin eff_cfg = pin_q;   low_power = 1'b0;    end
      MD_SW: begin eff_cfg = reg_cfg; low_power = reg_pdn; end
      default: begin eff_cfg = '0;    low_power = 1'b1;    end
    endcase
  end

  AST_PINS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_HW) |=> $stable(pin_q)) else $error("pins re-sampled"); // R6

  AST_WAIT_LOW_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_WAIT) |-> (low_power && eff_cfg == '0)) else $error("wait outputs"); // R1

endmodule

// File: rtl/pwrup_mode_seq.sv
module pwrup_mode_seq #(
  parameter int BASE_WAIT = 512,
  parameter int CNT_W     = 12,
  parameter int CFG_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lrck_tick,
  input  logic [1:0]       speed_sel,
  input  logic             cp_en_wr,
  input  logic [CFG_W-1:0] mode_pins,
  input  logic [CFG_W-1:0] reg_cfg,
  input  logic             reg_pdn,
  output logic             low_power,
  output logic [1:0]       active_mode,
  output logic [CFG_W-1:0] eff_cfg
);
  import pwrup_pkg::*;

  logic   rst_ns;
  logic   expire;
  logic   enter_hw;
  pmode_e mode;

  pwrup_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  pwrup_frame_cnt #(.BASE_WAIT(BASE_WAIT), .CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_ns),
    .run    (mode == MD_WAIT),
    .tick   (lrck_tick),
    .speed  (speed_sel),
    .expire (expire)
  );

  pwrup_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_ns),
    .expire   (expire),
    .cp_en_wr (cp_en_wr),
    .mode_q   (mode),
    .enter_hw (enter_hw)
  );

  pwrup_cfg_sel #(.CFG_W(CFG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_ns),
    .mode      (mode),
    .enter_hw  (enter_hw),
    .pins      (mode_pins),
    .reg_cfg   (reg_cfg),
    .reg_pdn   (reg_pdn),
    .eff_cfg   (eff_cfg),
    .low_power (low_power)
  );

  assign active_mode = mode;

endmodule

// File: tb/pwrup_mode_seq_test.sv
`timescale 1ns/1ps
module pwrup_mode_seq_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lrck_tick;
  logic [1:0] speed_sel;
  logic       cp_en_wr;
  logic [4:0] mode_pins;
  logic [4:0] reg_cfg;
  logic       reg_pdn;
  logic       low_power;
  logic [1:0] active_mode;
  logic [4:0] eff_cfg;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  pwrup_mode_seq uut (
    .clk(clk), .rst_n(rst_n), .lrck_tick(lrck_tick), .speed_sel(speed_sel),
    .cp_en_wr(cp_en_wr), .mode_pins(mode_pins), .reg_cfg(reg_cfg),
    .reg_pdn(reg_pdn), .low_power(low_power), .active_mode(active_mode),
    .eff_cfg(eff_cfg)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp_v);
    total = total + 1;
    if (act != exp_v) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic chk_out(string tag, int md, int lp, int cfg);
    chk({tag, " mode"}, int'(active_mode), md);
    chk({tag, " low_power"}, int'(low_power), lp);
    chk({tag, " cfg"}, int'(eff_cfg), cfg);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lrck_tick = 1'b0; cp_en_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk_out("R1 in reset", 0, 1, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_out("R1 after release", 0, 1, 0);
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      lrck_tick = 1'b1;
      @(negedge clk);
      lrck_tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  function automatic int wait_len(int spd);
    if (spd == 0) return 512;
    if (spd == 1) return 1024;
    return 2048;
  endfunction

  initial begin
    rst_n = 1'b0; lrck_tick = 1'b0; speed_sel = 2'b00; cp_en_wr = 1'b0;
    mode_pins = 5'h00; reg_cfg = 5'h00; reg_pdn = 1'b1;
    @(negedge clk);

    // R2 R3 R5 R6 R7 R8 R9 R10: full hardware path for each speed code
    for (int spd = 0; spd < 4; spd++) begin
      int n;
      int pins;
      n = wait_len(spd);
      pins = (spd * 7 + 5) & 31;
      speed_sel = 2'(spd);
      do_reset();
      mode_pins = 5'(pins);
      ticks(n - 1, 0);
      chk_out(spd == 3 ? "R3 wait one short" : "R2 wait one short", 0, 1, 0);
      repeat (4) @(negedge clk);
      chk("R2 idle cycles do not count", int'(active_mode), 0);
      ticks(1, 0);
      chk_out("R5 R10 hardware entry", 1, 0, pins);
      mode_pins = ~5'(pins);
      ticks(3, 1);
      chk_out("R6 pins ignored in hw", 1, 0, pins);
      reg_cfg = 5'(31 - spd); reg_pdn = 1'b1;
      cp_en_wr = 1'b1; @(negedge clk); cp_en_wr = 1'b0;
      chk_out("R7 R10 hw to sw", 2, 1, 31 - spd);
      reg_pdn = 1'b0; reg_cfg = 5'(spd + 9); #1;
      chk_out("R8 pdn cleared", 2, 0, spd + 9);
      ticks(5, 0);
      cp_en_wr = 1'b1; @(negedge clk); cp_en_wr = 1'b0;
      chk_out("R9 sw sticky", 2, 0, spd + 9);
    end

    // R2: spaced strobes, single speed
    speed_sel = 2'b00; mode_pins = 5'h15;
    do_reset();
    ticks(511, 2);
    chk("R2 spaced one short", int'(active_mode), 0);
    ticks(1, 0);
    chk_out("R2 spaced expiry", 1, 0, 5'h15);

    // R4: early write
    speed_sel = 2'b01; reg_cfg = 5'h0A; reg_pdn = 1'b1;
    do_reset();
    ticks(100, 0);
    cp_en_wr = 1'b1; @(negedge clk); cp_en_wr = 1'b0;
    chk_out("R4 early write", 2, 1, 5'h0A);
    ticks(1100, 0);
    chk("R9 no later hw entry", int'(active_mode), 2);

    // R4: write on the final strobe wins
    speed_sel = 2'b00;
    do_reset();
    ticks(511, 0);
    cp_en_wr = 1'b1; lrck_tick = 1'b1; @(negedge clk);
    cp_en_wr = 1'b0; lrck_tick = 1'b0;
    chk_out("R4 tie goes to write", 2, 1, 5'h0A);

    // R1: reset from hardware mode returns to wait
    mode_pins = 5'h03;
    do_reset();
    ticks(512, 0);
    chk("R1 pre-reset hw", int'(active_mode), 1);
    do_reset();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule